// File: doc/BRIEF.md
# Single-Channel Programmable Trigger Prescaler

This block thins out a stream of trigger pulses for one channel. A 16-bit modulus is programmed from outside. The block counts accepted triggers downward from that modulus. It forwards only the trigger that arrives while the count sits at zero, and at that same trigger it reloads the count from the modulus. A modulus of N therefore lets one trigger out of every N+1 pass, and a modulus of 0 lets every trigger pass.

Two controls gate the channel. A per-channel enable bit freezes the counter and silences the output while it is low. A global veto silences the output but leaves counting untouched, so the pass pattern carries on in step during a vetoed interval. The modulus input is read only when the count reloads. A new value written part-way through a cycle therefore takes effect only once the cycle in progress has completed. A trigger array is built by placing one instance per channel. The current count is brought out for debug.

Top module: `prescale_channel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_view` becomes the value on `modulus` and `trig_out` becomes 0 after that edge.
- R2: An accepted trigger (`trig_in` and `enable` both high) that meets a nonzero count lowers `count_view` by exactly one after the edge, and `trig_out` stays 0.
- R3: An accepted trigger that meets a count of zero reloads `count_view` with the `modulus` value present at that edge. When `veto` is low, it also drives `trig_out` high for exactly the following cycle.
- R4: With modulus N, enable high and veto low, the triggers that pass are the (N+1)th, 2(N+1)th, and so on after reset. A modulus of 0 passes every trigger, and a modulus of 65535 passes none of the first 65535.
- R5: A change on `modulus` while the count is nonzero leaves `count_view` unchanged. The new value is loaded at the next reload.
- R6: While `enable` is low, `count_view` holds its value and `trig_out` stays 0, whatever `trig_in` does.
- R7: While `veto` is high, `trig_out` stays 0, but accepted triggers still decrement and reload the count exactly as in R2 and R3.
- R8: In a cycle without an accepted trigger, `count_view` does not change and `trig_out` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the count from `modulus` |
| trig_in | input | 1 | Trigger pulse, one clock wide, already synchronous to `clk` |
| modulus | input | 16 | Prescale modulus N; one trigger in N+1 passes |
| enable | input | 1 | Channel enable; low freezes the count and blocks the output |
| veto | input | 1 | Global veto; high blocks the output while counting continues |
| trig_out | output | 1 | Registered, one-clock-wide gated trigger |
| count_view | output | 16 | Current down-count, for debug |

## Verification
The properties assume that `trig_in`, `enable`, `veto` and `modulus` are synchronous to `clk` and settled at each rising edge, and that `trig_in` is a single-cycle pulse that carries no meaning while `rst` is high. The bench changes every input only at the falling edge and samples the outputs shortly after the rising edge, so every input is stable around each sampling edge. It separates trigger pulses with at least one idle cycle, which matches the pulse form the block expects. Reset is always asserted from time zero, so no property looks back at values from before the first edge.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

   // Per-cycle action the counter takes on an accepted or idle cycle.
   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,   // no accepted trigger: hold
      ACT_STEP = 2'd1,   // accepted trigger, count nonzero: decrement
      ACT_WRAP = 2'd2    // accepted trigger at zero: pass and reload
   } prescale_act_e;

   // Smallest counter width the block accepts.
   localparam int unsigned MIN_CNT_W = 2;

   function automatic logic is_wrap(input prescale_act_e a);
      return a == ACT_WRAP;
   endfunction

endpackage

// File: rtl/prescale_accept.sv
module prescale_accept
   import prescale_pkg::*;
(
   input  logic          trig_in,
   input  logic          enable,
   input  logic          at_terminal,
   output prescale_act_e act
);

   logic accepted;

   assign accepted = trig_in & enable;

   always_comb begin
      if (!accepted)
         act = ACT_IDLE;
      else if (at_terminal)
         act = ACT_WRAP;
      else
         act = ACT_STEP;
   end

endmodule

// File: rtl/prescale_downcount.sv
module prescale_downcount
   import prescale_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter bit          TC_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  prescale_act_e    act,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             at_terminal
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < MIN_CNT_W) begin : g_bad_width
      $error("prescale_downcount: CNT_W below minimum");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= load_val;
      end else begin
         case (act)
            ACT_STEP: cnt_q <= cnt_q - CNT_ONE;
            ACT_WRAP: cnt_q <= load_val;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;

   // Terminal detection: either a wide compare on the count, or a flag
   // kept in step with the count so the gating path starts at a flop.
   if (TC_REG) begin : g_tc_flop
      logic tc_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            tc_q <= (load_val == CNT_ZERO);
         end else begin
            case (act)
               ACT_STEP: tc_q <= (cnt_q == CNT_ONE);
               ACT_WRAP: tc_q <= (load_val == CNT_ZERO);
               default:  tc_q <= tc_q;
            endcase
         end
      end
      assign at_terminal = tc_q;
   end else begin : g_tc_compare
      assign at_terminal = (cnt_q == CNT_ZERO);
   end

endmodule

// File: rtl/prescale_outgate.sv
module prescale_outgate
   import prescale_pkg::*;
(
   input  logic          clk,
   input  logic          rst,
   input  prescale_act_e act,
   input  logic          veto,
   output logic          trig_out
);

   logic out_q;

   always_ff @(posedge clk) begin
      if (rst)
         out_q <= 1'b0;
      else
         out_q <= is_wrap(act) & ~veto;
   end

   assign trig_out = out_q;

endmodule

// File: rtl/prescale_channel.sv
module prescale_channel
   import prescale_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter bit          TC_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] modulus,
   input  logic             enable,
   input  logic             veto,
   output logic             trig_out,
   output logic [CNT_W-1:0] count_view
);

   if (CNT_W > 32) begin : g_bad_top_width
      $error("prescale_channel: CNT_W above 32 not supported");
   end

   prescale_act_e    act;
   logic             at_terminal;
   logic [CNT_W-1:0] count;

   prescale_accept u_accept (
      .trig_in     (trig_in),
      .enable      (enable),
      .at_terminal (at_terminal),
      .act         (act)
   );

   prescale_downcount #(
      .CNT_W  (CNT_W),
      .TC_REG (TC_REG)
   ) u_count (
      .clk         (clk),
      .rst         (rst),
      .act         (act),
      .load_val    (modulus),
      .count       (count),
      .at_terminal (at_terminal)
   );

   prescale_outgate u_gate (
      .clk      (clk),
      .rst      (rst),
      .act      (act),
      .veto     (veto),
      .trig_out (trig_out)
   );

   assign count_view = count;

endmodule

// File: rtl/prescale_channel_chk.sv
module prescale_channel_chk #(
   parameter int unsigned CNT_W = 16
)(
   input logic             clk,
   input logic             rst,
   input logic             trig_in,
   input logic [CNT_W-1:0] modulus,
   input logic             enable,
   input logic             veto,
   input logic             trig_out,
   input logic [CNT_W-1:0] count_view
);

   localparam logic [CNT_W-1:0] ZERO = '0;

   // R2
   step_down_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_in && enable && count_view != ZERO)
      |=> (count_view == $past(count_view) - 1'b1) && !trig_out);

   // R3
   wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_in && enable && count_view == ZERO)
      |=> count_view == $past(modulus));

   // R7
   wrap_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_in && enable && count_view == ZERO)
      |=> trig_out == !$past(veto));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(trig_in && enable) |=> $stable(count_view) && !trig_out);

   // R6
   masked_out_chk: assert property (@(posedge clk) disable iff (rst)
      trig_out |-> $past(trig_in && enable && !veto));

endmodule

bind prescale_channel prescale_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .trig_in    (trig_in),
   .modulus    (modulus),
   .enable     (enable),
   .veto       (veto),
   .trig_out   (trig_out),
   .count_view (count_view)
);

// File: tb/prescale_channel_test.sv
`timescale 1ns/1ps
module prescale_channel_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        trig_in = 1'b0;
   logic [15:0] modulus = 16'd0;
   logic        enable = 1'b1;
   logic        veto = 1'b0;
   logic        trig_out;
   logic [15:0] count_view;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int unsigned m_cnt;
   int unsigned passes;

   always #10 clk = ~clk;   // 50 MHz

   prescale_channel uut (
      .clk        (clk),
      .rst        (rst),
      .trig_in    (trig_in),
      .modulus    (modulus),
      .enable     (enable),
      .veto       (veto),
      .trig_out   (trig_out),
      .count_view (count_view)
   );

   typedef struct packed {
      logic [15:0] mod;
      logic        en;
      logic        vt;
      logic [7:0]  ntrig;
      logic [7:0]  exp_pass;
      logic [15:0] exp_cnt;
   } row_t;

   localparam row_t ROWS [8] = '{
      '{16'd0,     1'b1, 1'b0, 8'd5,  8'd5, 16'd0},
      '{16'd1,     1'b1, 1'b0, 8'd6,  8'd3, 16'd1},
      '{16'd3,     1'b1, 1'b0, 8'd10, 8'd2, 16'd1},
      '{16'd4,     1'b0, 1'b0, 8'd7,  8'd0, 16'd4},
      '{16'd2,     1'b1, 1'b1, 8'd7,  8'd0, 16'd1},
      '{16'd5,     1'b1, 1'b0, 8'd5,  8'd0, 16'd0},
      '{16'd65535, 1'b1, 1'b0, 8'd3,  8'd0, 16'd65532},
      '{16'd2,     1'b1, 1'b0, 8'd9,  8'd3, 16'd2}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      trig_in = 1'b0;
      @(posedge clk);
      #2;
      m_cnt = modulus;
      passes = 0;
      chk("R1 count after reset", count_view, m_cnt);
      chk("R1 out after reset", trig_out, 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // One cycle with trig_in = t, followed by an idle cycle; model from R2-R8.
   task automatic cycle_pair(input bit t);
      bit exp_out;
      @(negedge clk);
      trig_in = t;
      exp_out = 1'b0;
      if (t && enable) begin
         if (m_cnt == 0) begin
            exp_out = !veto;
            m_cnt = modulus;
         end else begin
            m_cnt = m_cnt - 1;
         end
      end
      @(posedge clk);
      #2;
      if (exp_out) passes++;
      chk("R4 R7 trig_out per trigger", trig_out, exp_out);
      chk("R2 R6 count per trigger", count_view, m_cnt);
      @(negedge clk);
      trig_in = 1'b0;
      @(posedge clk);
      #2;
      chk("R8 idle out", trig_out, 0);
      chk("R8 idle count", count_view, m_cnt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // Table walk: each row starts from reset.
      for (int r = 0; r < 8; r++) begin
         @(negedge clk);
         modulus = ROWS[r].mod;
         enable = 1'b1;
         veto = 1'b0;
         do_reset();
         enable = ROWS[r].en;
         veto = ROWS[r].vt;
         for (int k = 0; k < int'(ROWS[r].ntrig); k++) cycle_pair(1'b1);
         chk("R4 table pass total", passes, ROWS[r].exp_pass);
         chk("R4 table final count", count_view, ROWS[r].exp_cnt);
      end

      // R1: reset loads the modulus value.
      @(negedge clk);
      enable = 1'b1; veto = 1'b0; modulus = 16'd7;
      do_reset();
      chk("R1 directed count 7", count_view, 7);

      // R5: mid-count modulus change.
      @(negedge clk);
      modulus = 16'd3;
      do_reset();
      cycle_pair(1'b1);
      cycle_pair(1'b1);
      chk("R5 count before change", count_view, 1);
      @(negedge clk);
      modulus = 16'd9;
      @(posedge clk); #2;
      chk("R5 count unchanged by new modulus", count_view, 1);
      cycle_pair(1'b1);
      chk("R5 count reached zero", count_view, 0);
      cycle_pair(1'b1);
      chk("R5 pass on old cycle", passes, 1);
      chk("R5 new modulus loaded", count_view, 9);

      // R6: mask mid-count freezes count and output.
      @(negedge clk);
      modulus = 16'd2;
      do_reset();
      cycle_pair(1'b1);
      enable = 1'b0;
      for (int k = 0; k < 4; k++) cycle_pair(1'b1);
      chk("R6 masked count frozen", count_view, 1);
      enable = 1'b1;
      cycle_pair(1'b1);
      cycle_pair(1'b1);
      chk("R6 pass after unmask", passes, 1);

      // R7: veto at the wrap point still reloads.
      @(negedge clk);
      modulus = 16'd1;
      do_reset();
      cycle_pair(1'b1);
      veto = 1'b1;
      cycle_pair(1'b1);
      chk("R7 vetoed wrap reloads", count_view, 1);
      chk("R7 no pass under veto", passes, 0);
      veto = 1'b0;
      cycle_pair(1'b1);
      cycle_pair(1'b1);
      chk("R7 pattern continues after veto", passes, 1);

      // R3: modulus 0 with back-to-back pulses separated by idles.
      @(negedge clk);
      modulus = 16'd0;
      do_reset();
      for (int k = 0; k < 3; k++) cycle_pair(1'b1);
      chk("R3 every trigger passes at zero modulus", passes, 3);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule